// File: doc/BRIEF.md
# Reset Entry Sequencer

This block runs the core-side reset entry of a small 32-bit processor. Two reset requests reach it: power-on and manual. It samples both on every clock edge. A power-on request aborts all work in flight at once. A manual request waits until the memory access on the bus has finished.

Whichever reset is accepted, the block then performs one entry step. That step forces the privilege, exception-block and register-bank bits of the status register to one. It records which reset occurred in an event-code register. It sends the fetch unit to the fixed handler address with a single-cycle redirect.

The block also holds the trap-immediate register. A trap instruction loads this register, and software may also write it. The 8-bit immediate sits at bits 9:2 of a 32-bit word, and every other bit reads as zero.

Top module: `rst_entry_seq`

## Requirements
- R1: Both reset request inputs are sampled at every rising clock edge. A request that is high for a single edge is accepted.
- R2: A power-on request seen at an edge starts the entry step in the very next cycle, even if `bus_busy_i` is high. `flush_o` is high during that entry cycle.
- R3: A manual request seen while `bus_busy_i` is high starts no entry while the bus stays busy. The entry step comes in the cycle after the first edge at which `bus_busy_i` is seen low. A manual entry never raises `flush_o`.
- R4: If both requests are high at the same edge, the power-on entry is taken. A power-on request that arrives while a manual reset is waiting takes over at once, and no manual entry follows.
- R5: During the entry cycle `sr_we_o` is 1, and `sr_md_o`, `sr_bl_o` and `sr_rb_o` are all 1. Outside it, all four are 0.
- R6: `evt_code_o` becomes 12'h000 for a power-on entry and 12'h020 for a manual entry, from the entry cycle onward. It keeps that value until the next entry.
- R7: `redirect_vld_o` is high for exactly the one entry cycle, with `redirect_pc_o` = 32'hA000_0000. At all other times `redirect_pc_o` is 0.
- R8: Further manual requests that arrive while a manual reset is waiting are absorbed. Exactly one entry results.
- R9: When `trap_exec_i` is high at an edge, `trap_reg_o[9:2]` takes `trap_imm_i` from the next cycle.
- R10: When `sw_wr_i` is high at an edge, `trap_reg_o[9:2]` takes `sw_wdata_i[9:2]`. Bits 31:10 and 1:0 of `trap_reg_o` always read 0.
- R11: If a trap load and a software write occur at the same edge, the trap immediate wins.
- R12: After `rst`, the event code, the trap register and every pulse output are 0. The trap register keeps its value when neither load is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| por_req_i | input | 1 | Power-on reset request |
| man_req_i | input | 1 | Manual reset request |
| bus_busy_i | input | 1 | A memory access is in progress |
| trap_exec_i | input | 1 | Trap instruction executes this cycle |
| trap_imm_i | input | 8 | Immediate of the trap instruction |
| sw_wr_i | input | 1 | Software write to the trap register |
| sw_wdata_i | input | 32 | Software write data |
| flush_o | output | 1 | Cancel all outstanding work (power-on entry) |
| sr_we_o | output | 1 | Status register update strobe |
| sr_md_o | output | 1 | Privileged-mode bit value |
| sr_bl_o | output | 1 | Exception-block bit value |
| sr_rb_o | output | 1 | Register-bank bit value |
| evt_code_o | output | 12 | Exception event code |
| redirect_vld_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target address |
| trap_reg_o | output | 32 | Trap-immediate register read value |

## Verification
The assertions check the following on every cycle:
- a power-on request forces a flushed entry one cycle later;
- a manual request with a busy bus yields no entry in the following cycle;
- every entry carries all three status bits and the fixed vector;
- the event code changes only in an entry cycle;
- both trap-register load paths land in the immediate field.

Only the bench scenarios can show the cycle at which a deferred manual entry finally appears. The same holds for the absorption of repeated manual requests into one entry, the power-on preemption of a waiting manual reset, and the values the event code keeps across idle periods.

// File: rtl/rst_entry_pkg.sv
package rst_entry_pkg;

    parameter int XLEN    = 32;
    parameter int EVT_W   = 12;
    parameter int IMM_W   = 8;
    parameter int IMM_LSB = 2;

    localparam logic [XLEN-1:0]  HANDLER_VEC = 32'hA000_0000;
    localparam logic [EVT_W-1:0] EVT_POWER   = 12'h000;
    localparam logic [EVT_W-1:0] EVT_MANUAL  = 12'h020;

    typedef enum logic [1:0] {
        SEQ_RUN   = 2'd0,
        SEQ_HOLD  = 2'd1,
        SEQ_ENTER = 2'd2
    } seq_state_e;

    typedef enum logic {
        KIND_POWER  = 1'b0,
        KIND_MANUAL = 1'b1
    } rst_kind_e;

    typedef struct packed {
        logic md;
        logic bl;
        logic rb;
    } sr_upd_t;

    function automatic logic [EVT_W-1:0] evt_for(rst_kind_e k);
        return (k == KIND_POWER) ? EVT_POWER : EVT_MANUAL;
    endfunction

endpackage

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_entry_pkg::*;
#(
    parameter int EW = EVT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            por_req,
    input  logic            man_req,
    input  logic            bus_busy,
    output logic            enter,
    output rst_kind_e       kind,
    output logic [EW-1:0]   evt_code
);

    seq_state_e state_q, state_d;
    rst_kind_e  kind_q, kind_d;
    logic [EW-1:0] evt_q;

    always_comb begin
        state_d = SEQ_RUN;
        kind_d  = kind_q;
        unique case (state_q)
            SEQ_HOLD: begin
                if (por_req) begin
                    state_d = SEQ_ENTER;
                    kind_d  = KIND_POWER;
                end else if (!bus_busy) begin
                    state_d = SEQ_ENTER;
                    kind_d  = KIND_MANUAL;
                end else begin
                    state_d = SEQ_HOLD;
                end
            end
            default: begin
                if (por_req) begin
                    state_d = SEQ_ENTER;
                    kind_d  = KIND_POWER;
                end else if (man_req) begin
                    state_d = bus_busy ? SEQ_HOLD : SEQ_ENTER;
                    kind_d  = KIND_MANUAL;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_RUN;
            kind_q  <= KIND_POWER;
            evt_q   <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            if (state_d == SEQ_ENTER) begin
                evt_q <= EW'(evt_for(kind_d));
            end
        end
    end

    assign enter    = (state_q == SEQ_ENTER);
    assign kind     = kind_q;
    assign evt_code = evt_q;

endmodule

// File: rtl/entry_drive.sv
module entry_drive
    import rst_entry_pkg::*;
#(
    parameter int              XW  = XLEN,
    parameter logic [XW-1:0]   VEC = HANDLER_VEC
) (
    input  logic          enter,
    input  rst_kind_e     kind,
    output sr_upd_t       sr_upd,
    output logic          sr_we,
    output logic          flush,
    output logic          redir_vld,
    output logic [XW-1:0] redir_pc
);

    always_comb begin
        sr_upd    = '{md: enter, bl: enter, rb: enter};
        sr_we     = enter;
        flush     = enter && (kind == KIND_POWER);
        redir_vld = enter;
        redir_pc  = enter ? VEC : '0;
    end

endmodule

// File: rtl/trap_imm_reg.sv
module trap_imm_reg
    import rst_entry_pkg::*;
#(
    parameter int XW  = XLEN,
    parameter int IW  = IMM_W,
    parameter int LSB = IMM_LSB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hw_load,
    input  logic [IW-1:0] hw_imm,
    input  logic          sw_wr,
    input  logic [XW-1:0] sw_data,
    output logic [XW-1:0] rd_data
);

    localparam int TOP = LSB + IW;

    logic [IW-1:0] imm_q;
    logic          unused_sw_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            imm_q <= '0;
        end else if (hw_load) begin
            imm_q <= hw_imm;
        end else if (sw_wr) begin
            imm_q <= sw_data[LSB +: IW];
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[LSB +: IW] = imm_q;
    end

    assign unused_sw_bits = ^{sw_data[XW-1:TOP], sw_data[LSB-1:0]};

endmodule

// File: rtl/rst_entry_seq.sv
module rst_entry_seq
    import rst_entry_pkg::*;
#(
    parameter int                XW  = XLEN,
    parameter int                EW  = EVT_W,
    parameter int                IW  = IMM_W,
    parameter int                LSB = IMM_LSB,
    parameter logic [XW-1:0]     VEC = HANDLER_VEC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          por_req_i,
    input  logic          man_req_i,
    input  logic          bus_busy_i,
    input  logic          trap_exec_i,
    input  logic [IW-1:0] trap_imm_i,
    input  logic          sw_wr_i,
    input  logic [XW-1:0] sw_wdata_i,
    output logic          flush_o,
    output logic          sr_we_o,
    output logic          sr_md_o,
    output logic          sr_bl_o,
    output logic          sr_rb_o,
    output logic [EW-1:0] evt_code_o,
    output logic          redirect_vld_o,
    output logic [XW-1:0] redirect_pc_o,
    output logic [XW-1:0] trap_reg_o
);

    logic      enter;
    rst_kind_e kind;
    sr_upd_t   sr_upd;

    rst_seq_fsm #(.EW(EW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .por_req  (por_req_i),
        .man_req  (man_req_i),
        .bus_busy (bus_busy_i),
        .enter    (enter),
        .kind     (kind),
        .evt_code (evt_code_o)
    );

    entry_drive #(.XW(XW), .VEC(VEC)) u_drive (
        .enter     (enter),
        .kind      (kind),
        .sr_upd    (sr_upd),
        .sr_we     (sr_we_o),
        .flush     (flush_o),
        .redir_vld (redirect_vld_o),
        .redir_pc  (redirect_pc_o)
    );

    trap_imm_reg #(.XW(XW), .IW(IW), .LSB(LSB)) u_trap (
        .clk     (clk),
        .rst     (rst),
        .hw_load (trap_exec_i),
        .hw_imm  (trap_imm_i),
        .sw_wr   (sw_wr_i),
        .sw_data (sw_wdata_i),
        .rd_data (trap_reg_o)
    );

    assign sr_md_o = sr_upd.md;
    assign sr_bl_o = sr_upd.bl;
    assign sr_rb_o = sr_upd.rb;

endmodule

// File: rtl/rst_entry_chk.sv
module rst_entry_chk
    import rst_entry_pkg::*;
#(
    parameter int            XW  = XLEN,
    parameter int            EW  = EVT_W,
    parameter int            IW  = IMM_W,
    parameter int            LSB = IMM_LSB,
    parameter logic [XW-1:0] VEC = HANDLER_VEC
) (
    input logic          clk,
    input logic          rst,
    input logic          por_req_i,
    input logic          man_req_i,
    input logic          bus_busy_i,
    input logic          trap_exec_i,
    input logic [IW-1:0] trap_imm_i,
    input logic          sw_wr_i,
    input logic [XW-1:0] sw_wdata_i,
    input logic          flush_o,
    input logic          sr_we_o,
    input logic          sr_md_o,
    input logic          sr_bl_o,
    input logic          sr_rb_o,
    input logic [EW-1:0] evt_code_o,
    input logic          redirect_vld_o,
    input logic [XW-1:0] redirect_pc_o,
    input logic [XW-1:0] trap_reg_o
);

    // R2
    por_immediate_chk: assert property (@(posedge clk) disable iff (rst)
        por_req_i |=> (redirect_vld_o && flush_o && evt_code_o == EW'(EVT_POWER)));

    // R3
    man_defer_chk: assert property (@(posedge clk) disable iff (rst)
        (man_req_i && bus_busy_i && !por_req_i) |=> !redirect_vld_o);

    // R5
    sr_bits_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_vld_o |-> (sr_we_o && sr_md_o && sr_bl_o && sr_rb_o));

    // R5
    sr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !redirect_vld_o |-> !(sr_we_o || sr_md_o || sr_bl_o || sr_rb_o || flush_o));

    // R6
    man_code_chk: assert property (@(posedge clk) disable iff (rst)
        (redirect_vld_o && !flush_o) |-> evt_code_o == EW'(EVT_MANUAL));

    // R6
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !redirect_vld_o |-> $stable(evt_code_o));

    // R7
    vector_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_vld_o |-> redirect_pc_o == VEC);

    // R9
    trap_hw_chk: assert property (@(posedge clk) disable iff (rst)
        trap_exec_i |=> trap_reg_o[LSB +: IW] == $past(trap_imm_i));

    // R10
    trap_sw_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_i && !trap_exec_i) |=> trap_reg_o[LSB +: IW] == $past(sw_wdata_i[LSB +: IW]));

    // R12
    trap_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr_i && !trap_exec_i) |=> $stable(trap_reg_o));

endmodule

bind rst_entry_seq rst_entry_chk #(
    .XW(XW), .EW(EW), .IW(IW), .LSB(LSB), .VEC(VEC)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .por_req_i      (por_req_i),
    .man_req_i      (man_req_i),
    .bus_busy_i     (bus_busy_i),
    .trap_exec_i    (trap_exec_i),
    .trap_imm_i     (trap_imm_i),
    .sw_wr_i        (sw_wr_i),
    .sw_wdata_i     (sw_wdata_i),
    .flush_o        (flush_o),
    .sr_we_o        (sr_we_o),
    .sr_md_o        (sr_md_o),
    .sr_bl_o        (sr_bl_o),
    .sr_rb_o        (sr_rb_o),
    .evt_code_o     (evt_code_o),
    .redirect_vld_o (redirect_vld_o),
    .redirect_pc_o  (redirect_pc_o),
    .trap_reg_o     (trap_reg_o)
);

// File: tb/rst_entry_seq_test.sv
`timescale 1ns/1ps
module rst_entry_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por_req_i = 0, man_req_i = 0, bus_busy_i = 0;
    logic        trap_exec_i = 0, sw_wr_i = 0;
    logic [7:0]  trap_imm_i = '0;
    logic [31:0] sw_wdata_i = '0;
    logic        flush_o, sr_we_o, sr_md_o, sr_bl_o, sr_rb_o, redirect_vld_o;
    logic [11:0] evt_code_o;
    logic [31:0] redirect_pc_o, trap_reg_o;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    typedef struct {
        int          at;
        bit          pwr;
        logic [11:0] code;
        string       tag;
    } entry_t;
    entry_t expq[$];

    rst_entry_seq uut (
        .clk(clk), .rst(rst), .por_req_i(por_req_i), .man_req_i(man_req_i),
        .bus_busy_i(bus_busy_i), .trap_exec_i(trap_exec_i), .trap_imm_i(trap_imm_i),
        .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i), .flush_o(flush_o),
        .sr_we_o(sr_we_o), .sr_md_o(sr_md_o), .sr_bl_o(sr_bl_o), .sr_rb_o(sr_rb_o),
        .evt_code_o(evt_code_o), .redirect_vld_o(redirect_vld_o),
        .redirect_pc_o(redirect_pc_o), .trap_reg_o(trap_reg_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_entry(input bit pwr, input string tag);
        entry_t e;
        e.at   = cyc + 1;
        e.pwr  = pwr;
        e.code = pwr ? 12'h000 : 12'h020;
        e.tag  = tag;
        expq.push_back(e);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: every entry pulse must match the head of the expectation queue
    always @(negedge clk) begin
        if (!rst && redirect_vld_o) begin
            if (expq.size() == 0) begin
                compared++;
                mismatched++;
                $display("FAIL R8 unexpected entry at cycle %0d: actual 1 expected 0", cyc);
            end else begin
                entry_t e;
                e = expq.pop_front();
                check({e.tag, " cycle"}, cyc, e.at);
                check({e.tag, " flush"}, {31'b0, flush_o}, {31'b0, e.pwr});
                check({e.tag, " R6 code"}, {20'b0, evt_code_o}, {20'b0, e.code});
                check({e.tag, " R5 sr"}, {28'b0, sr_we_o, sr_md_o, sr_bl_o, sr_rb_o}, 32'hF);
                check({e.tag, " R7 pc"}, redirect_pc_o, 32'hA000_0000);
            end
        end
    end

    initial begin
        #(8 * 20000);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R12 reset evt", {20'b0, evt_code_o}, 32'h0);
        check("R12 reset trap", trap_reg_o, 32'h0);
        check("R12 reset pulses", {30'b0, redirect_vld_o, flush_o}, 32'h0);
        check("R7 idle pc", redirect_pc_o, 32'h0);

        // R2: power-on while bus busy, immediate
        step(); por_req_i = 1; bus_busy_i = 1; expect_entry(1, "R2");
        step(); por_req_i = 0; bus_busy_i = 0;
        step();

        // R1: single-edge manual pulse with idle bus
        step(); man_req_i = 1; expect_entry(0, "R1");
        step(); man_req_i = 0;
        step();

        // R3: manual deferred for three busy cycles
        step(); man_req_i = 1; bus_busy_i = 1;
        step(); man_req_i = 0;
        step();
        step(); bus_busy_i = 0; expect_entry(0, "R3");
        step(); step();

        // R8: repeated manual request during wait is absorbed
        step(); man_req_i = 1; bus_busy_i = 1;
        step(); man_req_i = 0;
        step(); man_req_i = 1;
        step(); man_req_i = 0; bus_busy_i = 0; expect_entry(0, "R8");
        step(); step(); step();

        // R6: manual code persists while idle
        @(negedge clk);
        check("R6 manual hold", {20'b0, evt_code_o}, 32'h020);

        // R4: simultaneous requests
        step(); por_req_i = 1; man_req_i = 1; expect_entry(1, "R4 both");
        step(); por_req_i = 0; man_req_i = 0;
        step();

        // R4: power-on preempts a waiting manual reset
        step(); man_req_i = 1; bus_busy_i = 1;
        step(); man_req_i = 0;
        step(); por_req_i = 1; expect_entry(1, "R4 preempt");
        step(); por_req_i = 0;
        step(); bus_busy_i = 0;
        step(); step(); step();
        @(negedge clk);
        check("R6 power hold", {20'b0, evt_code_o}, 32'h000);
        check("R7 idle pc after", redirect_pc_o, 32'h0);

        // Trap register
        step(); trap_exec_i = 1; trap_imm_i = 8'hA5;
        step(); trap_exec_i = 0;
        @(negedge clk);
        check("R9 hw load", trap_reg_o, 32'h0000_0294);
        step(); sw_wr_i = 1; sw_wdata_i = 32'hFFFF_FFFF;
        step(); sw_wr_i = 0;
        @(negedge clk);
        check("R10 sw write", trap_reg_o, 32'h0000_03FC);
        step(); sw_wr_i = 1; sw_wdata_i = 32'h0; trap_exec_i = 1; trap_imm_i = 8'h3C;
        step(); sw_wr_i = 0; trap_exec_i = 0;
        @(negedge clk);
        check("R11 hw wins", trap_reg_o, 32'h0000_00F0);
        step(); step(); step();
        @(negedge clk);
        check("R12 trap keep", trap_reg_o, 32'h0000_00F0);

        while (expq.size() != 0) begin
            entry_t e;
            e = expq.pop_front();
            compared++;
            mismatched++;
            $display("FAIL %s missing entry: actual none expected cycle %0d", e.tag, e.at);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule